// File: doc/BRIEF.md
# Exception Priority Vector Decoder

This block collects every exception request of a small 16-bit CPU system and names the one the CPU must service next. Three reset causes, an unimplemented-opcode trap, a software interrupt (which shares its slot with a debug request), one X-class interrupt and a parameterised set of I-class interrupt lines feed a fixed priority chain. The winner's 16-bit vector address and a pending flag are registered on the clock edge after the requests are sampled. The CPU fetches its handler address from that vector.

The I and X classes are each gated by the CPU's mask bit and by a separate inhibit input. A small promotion register, written by software, names one I line by the low byte of its vector. While that line is requesting, it beats every other I line. It does not beat the X interrupt or anything above it.

A registered wakeup output lets a stopped or waiting system resume. It rises when a serviceable I or X request is present in low-power mode. It also rises for any raw X request, even while X is masked or inhibited. All requests are taken to be synchronous to the clock. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `exc_vec_decoder`

## Requirements
- R1: After reset, pending and wakeup are 0, the vector output reads 0xFFFE, and the promotion register names I line 0 (low byte 0xF2).
- R2: Priority is fixed, from highest to lowest: external reset (0xFFFE), clock-monitor reset (0xFFFC), watchdog reset (0xFFFA), trap (0xFFF8), software interrupt (0xFFF6), X interrupt (0xFFF4), then the I lines.
- R3: I line k has vector 0xFFF2 - 2*k. Without promotion, the lowest-numbered requesting line wins.
- R4: When i_mask or i_inhibit is 1, I requests neither raise pending nor change the vector.
- R5: When x_mask or x_inhibit is 1, the X request neither raises pending nor changes the vector. I lines can still win in that case.
- R6: The resets, the trap and the software interrupt are serviced whatever the mask and inhibit inputs hold.
- R7: pending and vec_addr change on the first clock edge after a request appears, not before. When no serviceable request exists, pending is 0 and vec_addr keeps its last value.
- R8: While the I line named by the promotion register is requesting and serviceable, its vector wins over every other I line. It does not win over the X interrupt or any higher source.
- R9: A promotion write takes effect on the next clock edge only if the data byte is even, at most 0xF2 and at least 0xF2 - 2*(NUM_I-1). Any other write leaves the register unchanged.
- R10: wakeup is registered. It is 1 when low_power is 1 and either a serviceable I request exists or xirq_req is 1, whatever the X mask or inhibit. It is 0 whenever low_power is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_I | I-class request lines, line 0 highest |
| xirq_req | input | 1 | X-class interrupt request |
| swi_req | input | 1 | Software interrupt or debug request |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| rst_ext_req | input | 1 | External or power-on reset request |
| rst_clk_req | input | 1 | Clock-monitor reset request |
| rst_wdog_req | input | 1 | Watchdog reset request |
| i_mask | input | 1 | CPU I mask bit |
| x_mask | input | 1 | CPU X mask bit |
| i_inhibit | input | 1 | Blocks servicing of I requests |
| x_inhibit | input | 1 | Blocks servicing of the X request |
| low_power | input | 1 | System is in stop or wait mode |
| promo_wr_en | input | 1 | Write strobe for the promotion register |
| promo_wr_data | input | 8 | Vector low byte to promote |
| vec_addr | output | 16 | Registered vector of the winning request |
| pending | output | 1 | Registered flag: a serviceable request exists |
| wakeup | output | 1 | Registered wake request for stop or wait mode |

## Verification
The bench builds the decoder with NUM_I = 8, so the implemented I window runs from 0xFFF2 down to 0xFFE4. This makes the lowest implemented line easy to reach and test, and it places an even offset (0xE2) just below the window, where a promotion write must be refused. The same narrow window lets the vector table cover every source class in turn, every mask and inhibit combination, and the wakeup paths with only a few one-hot patterns.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam logic [7:0] VEC_PAGE  = 8'hFF;
  localparam logic [7:0] OFF_EXT   = 8'hFE;
  localparam logic [7:0] OFF_CLK   = 8'hFC;
  localparam logic [7:0] OFF_WDOG  = 8'hFA;
  localparam logic [7:0] OFF_TRAP  = 8'hF8;
  localparam logic [7:0] OFF_SWI   = 8'hF6;
  localparam logic [7:0] OFF_XIRQ  = 8'hF4;
  localparam logic [7:0] OFF_ITOP  = 8'hF2;
  localparam int         I_LINES_MAX = 61;

  // vector low byte of I line idx (line 0 sits just below the X slot)
  function automatic logic [7:0] i_offset(input int idx);
    return 8'(int'(OFF_ITOP) - 2 * idx);
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/exc_promo_reg.sv
module exc_promo_reg
  import exc_vec_pkg::*;
#(
  parameter int NUM_I = 61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] promo_off
);

  localparam logic [7:0] LOW_OFF = 8'(int'(OFF_ITOP) - 2 * (NUM_I - 1));

  logic [7:0] promo_q;
  logic [7:0] promo_d;
  logic       wr_ok;

  always_comb begin
    wr_ok   = wr_en && !wr_data[0] && (wr_data <= OFF_ITOP) && (wr_data >= LOW_OFF);
    promo_d = promo_q;
    if (wr_ok) promo_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     promo_q <= OFF_ITOP;
    else if (wr_ok) promo_q <= promo_d;
  end

  assign promo_off = promo_q;

  assert_promo_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!promo_q[0] && promo_q <= OFF_ITOP && promo_q >= LOW_OFF));

  assert_promo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(promo_q));

endmodule

// File: rtl/exc_irq_arb.sv
module exc_irq_arb
  import exc_vec_pkg::*;
#(
  parameter int NUM_I = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_I-1:0] req,
  input  logic [7:0]       promo_off,
  output logic             any_req,
  output logic [7:0]       win_off
);

  localparam logic [7:0] LOW_OFF = 8'(int'(OFF_ITOP) - 2 * (NUM_I - 1));

  logic [NUM_I-1:0] promo_hit;
  logic [7:0]       fixed_off;

  for (genvar g = 0; g < NUM_I; g++) begin : g_line
    localparam logic [7:0] MY_OFF = 8'(int'(OFF_ITOP) - 2 * g);
    assign promo_hit[g] = req[g] && (promo_off == MY_OFF);
  end

  // lowest index wins: scan downward so it is assigned last
  always_comb begin
    fixed_off = OFF_ITOP;
    for (int i = NUM_I - 1; i >= 0; i--) begin
      if (req[i]) fixed_off = i_offset(i);
    end
  end

  always_comb begin
    any_req = |req;
    win_off = fixed_off;
    if (|promo_hit) win_off = promo_off;
  end

  assert_win_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (!win_off[0] && win_off <= OFF_ITOP && win_off >= LOW_OFF));

  assert_promo_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(promo_hit));

endmodule

// File: rtl/exc_vec_decoder.sv
module exc_vec_decoder
  import exc_vec_pkg::*;
#(
  parameter int NUM_I = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_I-1:0] irq_req,
  input  logic             xirq_req,
  input  logic             swi_req,
  input  logic             trap_req,
  input  logic             rst_ext_req,
  input  logic             rst_clk_req,
  input  logic             rst_wdog_req,
  input  logic             i_mask,
  input  logic             x_mask,
  input  logic             i_inhibit,
  input  logic             x_inhibit,
  input  logic             low_power,
  input  logic             promo_wr_en,
  input  logic [7:0]       promo_wr_data,
  output logic [15:0]      vec_addr,
  output logic             pending,
  output logic             wakeup
);

  localparam logic [15:0] VEC_RST = {VEC_PAGE, OFF_EXT};

  logic             rst_s_n;
  logic [NUM_I-1:0] i_serv;
  logic             x_serv;
  logic [7:0]       promo_off;
  logic             i_any;
  logic [7:0]       i_win_off;

  logic             sel_any;
  logic [7:0]       sel_off;
  logic [15:0]      vec_q, vec_d;
  logic             vec_en;
  logic             pend_q, pend_d;
  logic             wake_q, wake_d;

  exc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  exc_promo_reg #(.NUM_I(NUM_I)) u_promo (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en     (promo_wr_en),
    .wr_data   (promo_wr_data),
    .promo_off (promo_off)
  );

  always_comb begin
    i_serv = irq_req & {NUM_I{!i_mask && !i_inhibit}};
    x_serv = xirq_req && !x_mask && !x_inhibit;
  end

  exc_irq_arb #(.NUM_I(NUM_I)) u_arb (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .req       (i_serv),
    .promo_off (promo_off),
    .any_req   (i_any),
    .win_off   (i_win_off)
  );

  // fixed chain, highest address first
  always_comb begin
    sel_any = 1'b1;
    sel_off = vec_q[7:0];
    if (rst_ext_req)       sel_off = OFF_EXT;
    else if (rst_clk_req)  sel_off = OFF_CLK;
    else if (rst_wdog_req) sel_off = OFF_WDOG;
    else if (trap_req)     sel_off = OFF_TRAP;
    else if (swi_req)      sel_off = OFF_SWI;
    else if (x_serv)       sel_off = OFF_XIRQ;
    else if (i_any)        sel_off = i_win_off;
    else                   sel_any = 1'b0;
  end

  always_comb begin
    vec_en = sel_any;
    vec_d  = {VEC_PAGE, sel_off};
    pend_d = sel_any;
    wake_d = low_power && ((|i_serv) || xirq_req);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    vec_q <= VEC_RST;
    else if (vec_en) vec_q <= vec_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pend_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wake_q <= wake_d;
    end
  end

  assign vec_addr = vec_q;
  assign pending  = pend_q;
  assign wakeup   = wake_q;

  assert_ext_reset_top_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    rst_ext_req |=> (pending && vec_addr == 16'hFFFE));

  assert_trap_unmaskable_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (trap_req && !rst_ext_req && !rst_clk_req && !rst_wdog_req) |=> (pending && vec_addr == 16'hFFF8));

  assert_i_masked_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((i_mask || i_inhibit) && !xirq_req && !swi_req && !trap_req &&
     !rst_ext_req && !rst_clk_req && !rst_wdog_req) |=> !pending);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !pending |-> $stable(vec_addr));

  assert_xirq_wake_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (low_power && xirq_req) |=> wakeup);

  assert_awake_quiet_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !low_power |=> !wakeup);

endmodule

// File: tb/exc_vec_decoder_tb.sv
`timescale 1ns/1ps
module exc_vec_decoder_tb;

  localparam int NUM_I = 8;
  localparam int NROWS = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NUM_I-1:0] irq_req;
  logic xirq_req, swi_req, trap_req, rst_ext_req, rst_clk_req, rst_wdog_req;
  logic i_mask, x_mask, i_inhibit, x_inhibit, low_power;
  logic             promo_wr_en;
  logic [7:0]       promo_wr_data;
  logic [15:0]      vec_addr;
  logic             pending, wakeup;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  exc_vec_decoder #(.NUM_I(NUM_I)) u_dut (
    .clk, .rst_n, .irq_req, .xirq_req, .swi_req, .trap_req,
    .rst_ext_req, .rst_clk_req, .rst_wdog_req,
    .i_mask, .x_mask, .i_inhibit, .x_inhibit, .low_power,
    .promo_wr_en, .promo_wr_data, .vec_addr, .pending, .wakeup
  );

  typedef struct packed {
    logic [7:0]  irq;
    logic        x, swi, trap, ext, clkr, wdog;
    logic        im, xm, ii, xi, lp;
    logic        ep;
    logic [15:0] ev;
    logic        ew;
  } row_t;

  // irq, x, swi, trap, ext, clk, wdog, im, xm, ii, xi, lp | pend, vec, wake
  localparam row_t TBL [NROWS] = '{
    '{8'h01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFF2,1'b0}, // R3
    '{8'h80,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFE4,1'b0}, // R3
    '{8'h0C,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFEE,1'b0}, // R3
    '{8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,16'hFFEE,1'b0}, // R4
    '{8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,16'hFFEE,1'b0}, // R4
    '{8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFF4,1'b0}, // R5
    '{8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,16'hFFF4,1'b0}, // R5
    '{8'h02,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,16'hFFF0,1'b0}, // R5
    '{8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFF4,1'b0}, // R2
    '{8'h00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,16'hFFF6,1'b0}, // R6
    '{8'h00,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFF8,1'b0}, // R2
    '{8'h00,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b1,16'hFFFA,1'b0}, // R6
    '{8'h00,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFFC,1'b0}, // R2
    '{8'h00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFFE,1'b0}, // R2
    '{8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,16'hFFFE,1'b0}, // R7
    '{8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,16'hFFFE,1'b1}, // R10
    '{8'h04,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,16'hFFEE,1'b1}, // R10
    '{8'h04,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,16'hFFEE,1'b0}, // R10
    '{8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,16'hFFF4,1'b0}, // R10
    '{8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,16'hFFF4,1'b1}  // R10
  };

  function automatic string row_req(input int r);
    if (r < 3)       return "R3";
    else if (r < 5)  return "R4";
    else if (r < 8)  return "R5";
    else if (r == 9 || r == 11) return "R6";
    else if (r < 14) return "R2";
    else if (r == 14) return "R7";
    else             return "R10";
  endfunction

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got pend=%0b vec=%h wake=%0b, expected pend=%0b vec=%h wake=%0b",
               req, got[17], got[16:1], got[0], exp[17], exp[16:1], exp[0]);
    end
  endtask

  task automatic clear_inputs();
    irq_req = '0; xirq_req = 0; swi_req = 0; trap_req = 0;
    rst_ext_req = 0; rst_clk_req = 0; rst_wdog_req = 0;
    i_mask = 0; x_mask = 0; i_inhibit = 0; x_inhibit = 0; low_power = 0;
    promo_wr_en = 0; promo_wr_data = '0;
  endtask

  // drive at negedge, one posedge, land at the next negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic promo_write(input logic [7:0] d);
    promo_wr_en = 1'b1; promo_wr_data = d;
    step();
    promo_wr_en = 1'b0;
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1", {pending, vec_addr, wakeup}, {1'b0, 16'hFFFE, 1'b0});

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int r = 0; r < NROWS; r++) begin
      irq_req = TBL[r].irq; xirq_req = TBL[r].x; swi_req = TBL[r].swi;
      trap_req = TBL[r].trap; rst_ext_req = TBL[r].ext; rst_clk_req = TBL[r].clkr;
      rst_wdog_req = TBL[r].wdog; i_mask = TBL[r].im; x_mask = TBL[r].xm;
      i_inhibit = TBL[r].ii; x_inhibit = TBL[r].xi; low_power = TBL[r].lp;
      step();
      check(row_req(r), {pending, vec_addr, wakeup}, {TBL[r].ep, TBL[r].ev, TBL[r].ew});
    end

    // R7: output does not move before the clock edge
    clear_inputs();
    step();
    irq_req = 8'h01;
    #1;
    check("R7", {pending, vec_addr, wakeup}, {1'b0, 16'hFFF4, 1'b0});
    step();
    check("R7", {pending, vec_addr, wakeup}, {1'b1, 16'hFFF2, 1'b0});
    clear_inputs();

    // R8: promote line 5 (offset 0xE8) above line 0
    promo_write(8'hE8);
    irq_req = 8'h21;
    step();
    check("R8", {pending, vec_addr, wakeup}, {1'b1, 16'hFFE8, 1'b0});
    xirq_req = 1'b1;
    step();
    check("R8", {pending, vec_addr, wakeup}, {1'b1, 16'hFFF4, 1'b0});
    clear_inputs();

    // R9: odd, below-window and above-window writes are ignored
    promo_write(8'hE7);
    irq_req = 8'h21; step();
    check("R9", {pending, vec_addr, wakeup}, {1'b1, 16'hFFE8, 1'b0});
    irq_req = '0;
    promo_write(8'hE2);
    irq_req = 8'h21; step();
    check("R9", {pending, vec_addr, wakeup}, {1'b1, 16'hFFE8, 1'b0});
    irq_req = '0;
    promo_write(8'hF4);
    irq_req = 8'h21; step();
    check("R9", {pending, vec_addr, wakeup}, {1'b1, 16'hFFE8, 1'b0});
    irq_req = '0;

    // R9: lowest implemented line accepted
    promo_write(8'hE4);
    irq_req = 8'h81; step();
    check("R9", {pending, vec_addr, wakeup}, {1'b1, 16'hFFE4, 1'b0});
    clear_inputs();

    // R1: reset restores the promotion register to line 0
    do_reset();
    check("R1", {pending, vec_addr, wakeup}, {1'b0, 16'hFFFE, 1'b0});
    irq_req = 8'h81; step();
    check("R1", {pending, vec_addr, wakeup}, {1'b1, 16'hFFF2, 1'b0});
    clear_inputs();
    step();

    done = 1'b1;
    summary();
  end

endmodule